// File: doc/BRIEF.md
# AXI Burst Protocol Rule Checker

A passive monitor that sits beside one master-to-slave AXI4 link and watches its five channels: write address, write data, write response, read address and read data. It drives nothing onto the link. Every clock it evaluates a fixed set of protocol rules against the observed handshakes. When a rule is broken, that rule's sticky flag is raised. A summary error line and a saturating count of rule events sit next to the flags.

The rules cover four areas. First, VALID/payload holding while a handshake stalls. Second, the legality of each address phase: burst type, burst length, WRAP shape, transfer size against the bus width, and 4 KB crossing. Third, the position of the last-beat marker in each burst. Fourth, response and read-beat IDs checked against the bursts still open.

Write beats carry no ID, so they are matched to accepted write addresses in acceptance order. Read bursts are held in a per-ID table with room for one open burst per ID, 16 IDs by default. The block is meant for bring-up and for integration debug in silicon or emulation.

Top module: `axi_rule_monitor`

## Requirements
- R1: While a VALID is high and its READY low at a clock edge, the next cycle must keep that VALID high with the same payload (address, ID, length, size, burst type, WLAST, BID, RID or RLAST as applicable); otherwise flag bit 0 is raised.
- R2: A VALID on any channel that is high in the last cycle of reset raises flag bit 1 in the first cycle after reset is released.
- R3: An accepted write or read address with burst type 2'b11 raises flag bit 2 (burst encoding: 0 FIXED, 1 INCR, 2 WRAP, 3 reserved).
- R4: An accepted FIXED or WRAP burst whose length field exceeds 15 (more than 16 beats) raises flag bit 3; INCR bursts with any length field 0..255 (1 to 256 beats) do not.
- R5: An accepted WRAP burst whose length field is not 1, 3, 7 or 15, or whose address is not a multiple of 2^size bytes, raises flag bit 4.
- R6: An accepted address whose size field gives 2^size bytes per beat, more than DATA_W/8, raises flag bit 5.
- R7: An accepted INCR burst raises flag bit 6 when its last byte lies in a different 4 KB page from its start address. The last byte is the size-aligned start plus (len+1)*2^size minus 1.
- R8: Write beats are assigned to accepted write bursts in the order the addresses were accepted. A beat whose WLAST differs from "this is beat len+1 of its burst" raises flag bit 7.
- R9: Each read beat counts down the open burst of its RID. A beat whose RLAST differs from "no beats remain after this one" raises flag bit 8.
- R10: A write beat that arrives with no accepted write burst pending raises flag bit 9. An address accepted in the same cycle counts as pending.
- R11: A write response whose BID has no accepted, unanswered write address raises flag bit 10.
- R12: A read beat whose RID has no open read burst raises flag bit 11.
- R13: An accepted address whose ID already has an open burst in that direction raises flag bit 12 and leaves the existing entry unchanged.
- R14: Flags stay set until reset. The error output is high exactly when some flag is set. The count grows by the number of distinct rules that fire in a cycle and saturates. Synchronous active-low reset clears flags, count and all tracking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awid | input | ID_W | Write address ID |
| awaddr | input | ADDR_W | Write start address |
| awlen | input | 8 | Write burst length minus one |
| awsize | input | 3 | Write log2 bytes per beat |
| awburst | input | 2 | Write burst type |
| wvalid | input | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wlast | input | 1 | Final write beat marker |
| bvalid | input | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bid | input | ID_W | Write response ID |
| arvalid | input | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| arid | input | ID_W | Read address ID |
| araddr | input | ADDR_W | Read start address |
| arlen | input | 8 | Read burst length minus one |
| arsize | input | 3 | Read log2 bytes per beat |
| arburst | input | 2 | Read burst type |
| rvalid | input | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rid | input | ID_W | Read data ID |
| rlast | input | 1 | Final read beat marker |
| viol_flags | output | 13 | Sticky per-rule flags, bit n as listed in the requirements |
| viol_any | output | 1 | High when any flag is set |
| viol_count | output | CNT_W | Saturating count of rule events |

## Verification
The bound properties take as given that reset is held for at least one full clock before any checked cycle. They also assume each handshake input is a clean level sampled on the rising edge. None of them assumes a legal link, because reacting to illegal traffic is the block's whole purpose. The stimulus drives every link input on the falling edge, so each handshake is seen exactly once at the next rising edge. Each address-rule vector runs from a fresh reset, so one vector's table state cannot leak into the next.

// File: rtl/axi_mon_pkg.sv
package axi_mon_pkg;

  localparam int NRULE = 13;

  // Flag bit positions
  localparam int RB_STABLE   = 0;
  localparam int RB_RSTVALID = 1;
  localparam int RB_BTYPE    = 2;
  localparam int RB_LEN      = 3;
  localparam int RB_WRAP     = 4;
  localparam int RB_SIZE     = 5;
  localparam int RB_4K       = 6;
  localparam int RB_WLAST    = 7;
  localparam int RB_RLAST    = 8;
  localparam int RB_WORPHAN  = 9;
  localparam int RB_BID      = 10;
  localparam int RB_RID      = 11;
  localparam int RB_REUSE    = 12;

  localparam logic [1:0] BT_FIXED = 2'd0;
  localparam logic [1:0] BT_INCR  = 2'd1;
  localparam logic [1:0] BT_WRAP  = 2'd2;
  localparam logic [1:0] BT_RSVD  = 2'd3;

  // True when an INCR burst leaves the 4 KB page of its start address.
  function automatic logic page_crossed(input logic [11:0] lo, input logic [7:0] len,
                                        input logic [2:0] size);
    logic [11:0] aligned;
    logic [16:0] bytes;
    logic [16:0] last;
    aligned = lo & ~((12'd1 << size) - 12'd1);
    bytes   = ({9'd0, len} + 17'd1) << size;
    last    = {5'd0, aligned} + bytes - 17'd1;
    return last[16:12] != 5'd0;
  endfunction

  function automatic logic wrap_len_legal(input logic [7:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction

  function automatic logic size_misaligned(input logic [11:0] lo, input logic [2:0] size);
    return (lo & ((12'd1 << size) - 12'd1)) != 12'd0;
  endfunction

  function automatic int unsigned rule_hits(input logic [NRULE-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NRULE; i++) n += {31'd0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/axi_hs_stable.sv
module axi_hs_stable #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          ready,
  input  logic [PW-1:0] payload,
  output logic          evt
);
  logic          held_q;
  logic [PW-1:0] pay_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      pay_q  <= '0;
    end else begin
      held_q <= valid && !ready;
      pay_q  <= payload;
    end
  end

  assign evt = held_q && (!valid || (payload != pay_q));
endmodule

// File: rtl/axi_addr_rules.sv
module axi_addr_rules
  import axi_mon_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic        fire,
  input  logic [11:0] addr_lo,
  input  logic [7:0]  len,
  input  logic [2:0]  size,
  input  logic [1:0]  burst,
  output logic [4:0]  hit   // btype, len, wrap, size, 4k
);
  localparam int BUS_LG = $clog2(DATA_W / 8);

  logic is_short_kind;
  assign is_short_kind = (burst == BT_FIXED) || (burst == BT_WRAP);

  always_comb begin
    hit[0] = fire && (burst == BT_RSVD);
    hit[1] = fire && is_short_kind && (len > 8'd15);
    hit[2] = fire && (burst == BT_WRAP) &&
             (!wrap_len_legal(len) || size_misaligned(addr_lo, size));
    hit[3] = fire && (int'(size) > BUS_LG);
    hit[4] = fire && (burst == BT_INCR) && page_crossed(addr_lo, len, size);
  end
endmodule

// File: rtl/axi_burst_track.sv
module axi_burst_track #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            aw_fire,
  input  logic [ID_W-1:0] awid,
  input  logic [7:0]      awlen,
  input  logic            w_fire,
  input  logic            wlast,
  input  logic            b_fire,
  input  logic [ID_W-1:0] bid,
  input  logic            ar_fire,
  input  logic [ID_W-1:0] arid,
  input  logic [7:0]      arlen,
  input  logic            r_fire,
  input  logic [ID_W-1:0] rid,
  input  logic            rlast,
  output logic            ev_wlast,
  output logic            ev_rlast,
  output logic            ev_worphan,
  output logic            ev_bid,
  output logic            ev_rid,
  output logic            ev_reuse
);
  localparam int NID = 1 << ID_W;
  localparam logic [ID_W:0] FULL = NID[ID_W:0];

  // ---- write side: in-order length queue plus per-ID pending bits
  logic [7:0]      wq_mem [NID];
  logic [ID_W-1:0] wq_wp, wq_rp;
  logic [ID_W:0]   wq_cnt;
  logic [7:0]      wbeat_q;
  logic [NID-1:0]  wpend_q;

  logic aw_reuse, aw_new, push, have, w_end, w_is_last, store, release_q;
  logic [7:0] head;

  assign aw_reuse  = aw_fire && wpend_q[awid];
  assign aw_new    = aw_fire && !aw_reuse;
  assign push      = aw_new && (wq_cnt != FULL);
  assign have      = (wq_cnt != '0) || push;
  assign head      = (wq_cnt != '0) ? wq_mem[wq_rp] : awlen;
  assign w_end     = (wbeat_q == head);
  assign w_is_last = w_fire && have && w_end;
  assign store     = push && !((wq_cnt == '0) && w_is_last);
  assign release_q = w_is_last && (wq_cnt != '0);

  assign ev_worphan = w_fire && !have;
  assign ev_wlast   = w_fire && have && (wlast != w_end);
  assign ev_bid     = b_fire && !wpend_q[bid];

  always_ff @(posedge clk) begin
    if (store) wq_mem[wq_wp] <= awlen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wq_wp   <= '0;
      wq_rp   <= '0;
      wq_cnt  <= '0;
      wbeat_q <= '0;
      wpend_q <= '0;
    end else begin
      if (store)     wq_wp <= wq_wp + 1'b1;
      if (release_q) wq_rp <= wq_rp + 1'b1;
      if (store && !release_q)      wq_cnt <= wq_cnt + 1'b1;
      else if (!store && release_q) wq_cnt <= wq_cnt - 1'b1;
      if (w_fire && have) wbeat_q <= w_end ? 8'd0 : wbeat_q + 8'd1;
      for (int i = 0; i < NID; i++) begin
        if (b_fire && (bid == ID_W'(i)))        wpend_q[i] <= 1'b0;
        else if (aw_new && (awid == ID_W'(i))) wpend_q[i] <= 1'b1;
      end
    end
  end

  // ---- read side: one open burst per ID, remaining-beat countdown
  logic       ropen_q [NID];
  logic [7:0] rrem_q  [NID];
  logic ar_reuse, ar_new, r_known, r_end;

  assign ar_reuse = ar_fire && ropen_q[arid];
  assign ar_new   = ar_fire && !ar_reuse;
  assign r_known  = ropen_q[rid];
  assign r_end    = (rrem_q[rid] == 8'd0);

  assign ev_rid   = r_fire && !r_known;
  assign ev_rlast = r_fire && r_known && (rlast != r_end);
  assign ev_reuse = aw_reuse || ar_reuse;

  for (genvar g = 0; g < NID; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ropen_q[g] <= 1'b0;
        rrem_q[g]  <= 8'd0;
      end else if (ar_new && (arid == ID_W'(g))) begin
        ropen_q[g] <= 1'b1;
        rrem_q[g]  <= arlen;
      end else if (r_fire && (rid == ID_W'(g)) && ropen_q[g]) begin
        if (rrem_q[g] == 8'd0) ropen_q[g] <= 1'b0;
        else                   rrem_q[g]  <= rrem_q[g] - 8'd1;
      end
    end
  end
endmodule

// File: rtl/axi_rule_monitor.sv
module axi_rule_monitor
  import axi_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  input  logic              awready,
  input  logic [ID_W-1:0]   awid,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [7:0]        awlen,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic              wvalid,
  input  logic              wready,
  input  logic              wlast,
  input  logic              bvalid,
  input  logic              bready,
  input  logic [ID_W-1:0]   bid,
  input  logic              arvalid,
  input  logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [7:0]        arlen,
  input  logic [2:0]        arsize,
  input  logic [1:0]        arburst,
  input  logic              rvalid,
  input  logic              rready,
  input  logic [ID_W-1:0]   rid,
  input  logic              rlast,
  output logic [NRULE-1:0]  viol_flags,
  output logic              viol_any,
  output logic [CNT_W-1:0]  viol_count
);
  localparam int APW = ID_W + ADDR_W + 8 + 3 + 2;

  logic aw_fire, w_fire, b_fire, ar_fire, r_fire;
  assign aw_fire = awvalid && awready;
  assign w_fire  = wvalid && wready;
  assign b_fire  = bvalid && bready;
  assign ar_fire = arvalid && arready;
  assign r_fire  = rvalid && rready;

  // handshake holding
  logic ev_aw_hold, ev_w_hold, ev_b_hold, ev_ar_hold, ev_r_hold;

  axi_hs_stable #(.PW(APW)) u_hs_aw (
    .clk(clk), .rst_n(rst_n), .valid(awvalid), .ready(awready),
    .payload({awid, awaddr, awlen, awsize, awburst}), .evt(ev_aw_hold));
  axi_hs_stable #(.PW(1)) u_hs_w (
    .clk(clk), .rst_n(rst_n), .valid(wvalid), .ready(wready),
    .payload(wlast), .evt(ev_w_hold));
  axi_hs_stable #(.PW(ID_W)) u_hs_b (
    .clk(clk), .rst_n(rst_n), .valid(bvalid), .ready(bready),
    .payload(bid), .evt(ev_b_hold));
  axi_hs_stable #(.PW(APW)) u_hs_ar (
    .clk(clk), .rst_n(rst_n), .valid(arvalid), .ready(arready),
    .payload({arid, araddr, arlen, arsize, arburst}), .evt(ev_ar_hold));
  axi_hs_stable #(.PW(ID_W + 1)) u_hs_r (
    .clk(clk), .rst_n(rst_n), .valid(rvalid), .ready(rready),
    .payload({rid, rlast}), .evt(ev_r_hold));

  // address-phase legality, one checker per direction
  logic [4:0] aw_hit, ar_hit;

  axi_addr_rules #(.DATA_W(DATA_W)) u_rules_aw (
    .fire(aw_fire), .addr_lo(awaddr[11:0]), .len(awlen), .size(awsize),
    .burst(awburst), .hit(aw_hit));
  axi_addr_rules #(.DATA_W(DATA_W)) u_rules_ar (
    .fire(ar_fire), .addr_lo(araddr[11:0]), .len(arlen), .size(arsize),
    .burst(arburst), .hit(ar_hit));

  // beat and ID tracking
  logic ev_wlast, ev_rlast, ev_worphan, ev_bid, ev_rid, ev_reuse;

  axi_burst_track #(.ID_W(ID_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .aw_fire(aw_fire), .awid(awid), .awlen(awlen),
    .w_fire(w_fire), .wlast(wlast),
    .b_fire(b_fire), .bid(bid),
    .ar_fire(ar_fire), .arid(arid), .arlen(arlen),
    .r_fire(r_fire), .rid(rid), .rlast(rlast),
    .ev_wlast(ev_wlast), .ev_rlast(ev_rlast), .ev_worphan(ev_worphan),
    .ev_bid(ev_bid), .ev_rid(ev_rid), .ev_reuse(ev_reuse));

  // valid seen in the last reset cycle, reported after release
  logic any_valid, rst_valid_q;
  assign any_valid = awvalid || wvalid || bvalid || arvalid || rvalid;

  always_ff @(posedge clk) begin
    rst_valid_q <= !rst_n && any_valid;
  end

  logic [NRULE-1:0] ev;
  always_comb begin
    ev                      = '0;
    ev[RB_STABLE]           = ev_aw_hold || ev_w_hold || ev_b_hold || ev_ar_hold || ev_r_hold;
    ev[RB_RSTVALID]         = rst_valid_q;
    ev[RB_4K:RB_BTYPE]      = aw_hit | ar_hit;
    ev[RB_WLAST]            = ev_wlast;
    ev[RB_RLAST]            = ev_rlast;
    ev[RB_WORPHAN]          = ev_worphan;
    ev[RB_BID]              = ev_bid;
    ev[RB_RID]              = ev_rid;
    ev[RB_REUSE]            = ev_reuse;
  end

  logic [CNT_W:0] count_sum;
  assign count_sum = {1'b0, viol_count} + (CNT_W + 1)'(rule_hits(ev));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_flags <= '0;
      viol_count <= '0;
    end else begin
      viol_flags <= viol_flags | ev;
      viol_count <= count_sum[CNT_W] ? {CNT_W{1'b1}} : count_sum[CNT_W-1:0];
    end
  end

  assign viol_any = |viol_flags;
endmodule

// File: rtl/axi_rule_monitor_chk.sv
module axi_rule_monitor_chk
  import axi_mon_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             awvalid,
  input logic             awready,
  input logic [7:0]       awlen,
  input logic [1:0]       awburst,
  input logic             arvalid,
  input logic             arready,
  input logic [2:0]       arsize,
  input logic [NRULE-1:0] viol_flags,
  input logic [CNT_W-1:0] viol_count
);
  localparam int BUS_LG = $clog2(DATA_W / 8);

  a_r14_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (viol_flags == '0) && (viol_count == '0));

  a_r14_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

  a_r14_count_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_count == '0) == (viol_flags == '0));

  a_r14_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (viol_count >= $past(viol_count)));

  a_r1_aw_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) ##1 !awvalid |=> viol_flags[RB_STABLE]);

  a_r3_reserved_type: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && awready && (awburst == BT_RSVD)) |=> viol_flags[RB_BTYPE]);

  a_r4_fixed_too_long: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && awready && (awburst == BT_FIXED) && (awlen > 8'd15)) |=> viol_flags[RB_LEN]);

  a_r6_size_too_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && arready && (int'(arsize) > BUS_LG)) |=> viol_flags[RB_SIZE]);
endmodule

bind axi_rule_monitor axi_rule_monitor_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .awready(awready), .awlen(awlen),
  .awburst(awburst), .arvalid(arvalid), .arready(arready), .arsize(arsize),
  .viol_flags(viol_flags), .viol_count(viol_count));

// File: tb/tb_axi_rule_monitor.sv
module tb_axi_rule_monitor;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int ID_W   = 4;
  localparam int CNT_W  = 16;
  localparam int NR     = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic awvalid, awready, wvalid, wready, wlast, bvalid, bready;
  logic arvalid, arready, rvalid, rready, rlast;
  logic [ID_W-1:0] awid, bid, arid, rid;
  logic [ADDR_W-1:0] awaddr, araddr;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize;
  logic [1:0] awburst, arburst;
  logic [NR-1:0] viol_flags;
  logic viol_any;
  logic [CNT_W-1:0] viol_count;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  axi_rule_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awready(awready), .awid(awid), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst),
    .wvalid(wvalid), .wready(wready), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bid(bid),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr), .arlen(arlen),
    .arsize(arsize), .arburst(arburst),
    .rvalid(rvalid), .rready(rready), .rid(rid), .rlast(rlast),
    .viol_flags(viol_flags), .viol_any(viol_any), .viol_count(viol_count));

  // {addr, len, size, burst, expected flags}; each applied as one write address
  localparam logic [57:0] VEC [13] = '{
    {32'h0000_1000, 8'd255, 3'd3, 2'd1, 13'h000},  // R4 longest INCR, R7 inside page
    {32'h0000_1F00, 8'd31,  3'd3, 2'd1, 13'h000},  // R7 ends on last byte of page
    {32'h0000_1F08, 8'd31,  3'd3, 2'd1, 13'h040},  // R7 crosses
    {32'h0000_0000, 8'd16,  3'd3, 2'd0, 13'h008},  // R4 FIXED 17 beats
    {32'h0000_0000, 8'd15,  3'd3, 2'd0, 13'h000},  // R4 FIXED 16 beats
    {32'h0000_0040, 8'd3,   3'd3, 2'd2, 13'h000},  // R5 good WRAP
    {32'h0000_0040, 8'd2,   3'd3, 2'd2, 13'h010},  // R5 WRAP 3 beats
    {32'h0000_0044, 8'd3,   3'd3, 2'd2, 13'h010},  // R5 WRAP misaligned
    {32'h0000_0000, 8'd0,   3'd3, 2'd3, 13'h004},  // R3 reserved type
    {32'h0000_0000, 8'd0,   3'd4, 2'd1, 13'h020},  // R6 16 bytes on 8-byte bus
    {32'h0000_0000, 8'd31,  3'd2, 2'd2, 13'h018},  // R4 and R5 together
    {32'h0000_0FFC, 8'd0,   3'd3, 2'd1, 13'h000},  // R7 unaligned single beat
    {32'h0000_0FFC, 8'd1,   3'd3, 2'd1, 13'h040}   // R7 unaligned two beats cross
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    awvalid = 0; awready = 0; awid = '0; awaddr = '0; awlen = '0; awsize = 3'd3; awburst = 2'd1;
    wvalid = 0; wready = 0; wlast = 0;
    bvalid = 0; bready = 0; bid = '0;
    arvalid = 0; arready = 0; arid = '0; araddr = '0; arlen = '0; arsize = 3'd3; arburst = 2'd1;
    rvalid = 0; rready = 0; rid = '0; rlast = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic aw_send(input logic [3:0] id, input logic [31:0] a, input logic [7:0] l,
                         input logic [2:0] s, input logic [1:0] b);
    awvalid = 1; awready = 1; awid = id; awaddr = a; awlen = l; awsize = s; awburst = b;
    @(negedge clk);
    awvalid = 0; awready = 0;
  endtask

  task automatic ar_send(input logic [3:0] id, input logic [31:0] a, input logic [7:0] l,
                         input logic [2:0] s, input logic [1:0] b);
    arvalid = 1; arready = 1; arid = id; araddr = a; arlen = l; arsize = s; arburst = b;
    @(negedge clk);
    arvalid = 0; arready = 0;
  endtask

  task automatic w_beat(input logic last);
    wvalid = 1; wready = 1; wlast = last;
    @(negedge clk);
    wvalid = 0; wready = 0; wlast = 0;
  endtask

  task automatic r_beat(input logic [3:0] id, input logic last);
    rvalid = 1; rready = 1; rid = id; rlast = last;
    @(negedge clk);
    rvalid = 0; rready = 0; rlast = 0;
  endtask

  task automatic b_send(input logic [3:0] id);
    bvalid = 1; bready = 1; bid = id;
    @(negedge clk);
    bvalid = 0; bready = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    chk("R14 flags held clear in reset", 32'(viol_flags), 0);
    chk("R14 count held clear in reset", 32'(viol_count), 0);
    chk("R14 any low in reset", 32'(viol_any), 0);

    // address-phase rule table
    for (int i = 0; i < 13; i++) begin
      do_reset();
      aw_send(4'd0, VEC[i][57:26], VEC[i][25:18], VEC[i][17:15], VEC[i][14:13]);
      chk($sformatf("R3-R7 vector %0d flags", i), 32'(viol_flags), 32'(VEC[i][12:0]));
      chk($sformatf("R14 vector %0d count", i), 32'(viol_count), $countones(VEC[i][12:0]));
    end

    // R4/R7 on the read address channel
    do_reset();
    ar_send(4'd0, 32'h0, 8'd20, 3'd2, 2'd0);
    chk("R4 read FIXED 21 beats", 32'(viol_flags), 32'h008);
    do_reset();
    ar_send(4'd0, 32'hFF8, 8'd1, 3'd3, 2'd1);
    chk("R7 read INCR crossing", 32'(viol_flags), 32'h040);
    do_reset();
    ar_send(4'd0, 32'h0, 8'd0, 3'd6, 2'd1);
    chk("R6 read size 64 bytes", 32'(viol_flags), 32'h020);

    // R1 valid dropped while stalled
    do_reset();
    awvalid = 1; awaddr = 32'h100;
    @(negedge clk);
    awvalid = 0;
    @(negedge clk);
    chk("R1 write address dropped", 32'(viol_flags), 32'h001);
    // R1 payload changed while stalled
    do_reset();
    arvalid = 1;
    @(negedge clk);
    araddr = 32'h8;
    @(negedge clk);
    chk("R1 read address changed", 32'(viol_flags), 32'h001);
    arvalid = 0;
    // R1 legal stall
    do_reset();
    awvalid = 1; awaddr = 32'h200;
    @(negedge clk);
    awready = 1;
    @(negedge clk);
    awvalid = 0; awready = 0;
    @(negedge clk);
    chk("R1 legal stall then accept", 32'(viol_flags), 32'h000);

    // R2 valid high in the last reset cycle
    rst_n = 0;
    idle();
    @(negedge clk);
    rvalid = 1;
    @(negedge clk);
    rst_n = 1; rvalid = 0;
    @(negedge clk);
    chk("R2 valid during reset", 32'(viol_flags), 32'h002);

    // R8, R10, R11 write path
    do_reset();
    aw_send(4'd1, 32'h0, 8'd2, 3'd3, 2'd1);
    w_beat(0); w_beat(0); w_beat(1);
    chk("R8 three-beat burst clean", 32'(viol_flags), 32'h000);
    aw_send(4'd4, 32'h100, 8'd1, 3'd3, 2'd1);
    w_beat(1);
    chk("R8 early WLAST", 32'(viol_flags), 32'h080);
    w_beat(1);
    chk("R8 closing beat accepted", 32'(viol_flags), 32'h080);
    w_beat(0);
    chk("R10 beat with no burst", 32'(viol_flags), 32'h280);
    chk("R14 count of two rules", 32'(viol_count), 2);
    b_send(4'd1);
    chk("R11 response for pending ID", 32'(viol_flags), 32'h280);
    b_send(4'd1);
    chk("R11 second response same ID", 32'(viol_flags), 32'h680);

    // R10 address and data in the same cycle
    do_reset();
    awvalid = 1; awready = 1; awid = 4'd1; awlen = 8'd0;
    wvalid = 1; wready = 1; wlast = 1;
    @(negedge clk);
    idle();
    chk("R10 same-cycle address and beat", 32'(viol_flags), 32'h000);
    w_beat(1);
    chk("R10 extra beat after pop", 32'(viol_flags), 32'h200);

    // R13 ID reuse leaves the table unchanged
    do_reset();
    aw_send(4'd2, 32'h0, 8'd0, 3'd3, 2'd1);
    aw_send(4'd2, 32'h0, 8'd0, 3'd3, 2'd1);
    chk("R13 write ID reuse", 32'(viol_flags), 32'h1000);
    w_beat(1);
    chk("R13 first burst still tracked", 32'(viol_flags), 32'h1000);
    w_beat(1);
    chk("R13 second burst not queued", 32'(viol_flags), 32'h1200);
    do_reset();
    ar_send(4'd5, 32'h0, 8'd0, 3'd3, 2'd1);
    ar_send(4'd5, 32'h0, 8'd0, 3'd3, 2'd1);
    chk("R13 read ID reuse", 32'(viol_flags), 32'h1000);

    // R9, R12 read path
    do_reset();
    ar_send(4'd5, 32'h0, 8'd1, 3'd3, 2'd1);
    r_beat(4'd5, 0); r_beat(4'd5, 1);
    chk("R9 two-beat read clean", 32'(viol_flags), 32'h000);
    r_beat(4'd5, 1);
    chk("R12 beat for closed ID", 32'(viol_flags), 32'h800);
    do_reset();
    ar_send(4'd6, 32'h0, 8'd2, 3'd3, 2'd1);
    r_beat(4'd6, 1);
    chk("R9 early RLAST", 32'(viol_flags), 32'h100);

    // R14 stickiness and count
    repeat (3) @(negedge clk);
    chk("R14 flag persists", 32'(viol_flags), 32'h100);
    chk("R14 any high", 32'(viol_any), 1);
    chk("R14 count one", 32'(viol_count), 1);
    r_beat(4'd9, 0);
    chk("R12 unknown ID", 32'(viol_flags), 32'h900);
    chk("R14 count two", 32'(viol_count), 2);
    do_reset();
    chk("R14 reset clears flags", 32'(viol_flags), 0);
    chk("R14 reset clears count", 32'(viol_count), 0);
    chk("R14 reset clears any", 32'(viol_any), 0);

    summary();
  end
endmodule